// File: doc/BRIEF.md
# Line Strobe Latch with Polarity Steering

This block sits between the line capture logic and the analog stage of a column driver. It keeps one full line of 6-bit gray codes, one code per channel. A line strobe controls when the new codes reach the channels. When the strobe goes high, the captured line is frozen into an output latch and every channel is released to high impedance. When the strobe goes low again, the channels are driven with the new codes.

A polarity input chooses which reference half each channel uses. Neighbouring channels always sit on opposite halves. The polarity input swaps the two halves once per line, so the panel sees alternating drive.

A timing guard watches the strobe against the clock and against the start pulse of the next line. It raises a one-cycle error flag when the strobe is too short or when the next start pulse comes too soon after the strobe.

Top module: `line_strobe_latch`

## Requirements
- R1: On the first clock where `strobe_i` is sampled high after being low, the whole of `line_data_i` is captured. Changes to `line_data_i` after that clock do not affect the codes presented for this line.
- R2: `code_o` takes the captured line one cycle after the first clock that samples `strobe_i` low following a high period, and it holds that value at every other time. Channel k uses bits [k*CODE_W +: CODE_W] on both `line_data_i` and `code_o`.
- R3: `drive_en_o` is all zero from the cycle after the strobe is first sampled high until the strobe is sampled low. It becomes all ones in the same cycle that `code_o` updates.
- R4: Channel index k counts from 0. With polarity sampled low, even k has `upper_sel_o[k]`=1 (upper set) and odd k has 0. With polarity sampled high, the pattern is inverted. Polarity is sampled only at the strobe rise, so a change while the strobe is high has no effect.
- R5: A strobe that is sampled high on fewer than MIN_STB_CYC clocks (default 2) pulses `proto_err_o` for one cycle, one cycle after the falling sample. A strobe of MIN_STB_CYC or more clocks raises no error.
- R6: A `start_i` pulse sampled fewer than MIN_START_GAP clocks (default 2) after the strobe-rise clock (offset 0 or 1) pulses `proto_err_o` on the next cycle. At offset MIN_START_GAP or later, no error is raised.
- R7: During reset and after it, `code_o`, `upper_sel_o`, `drive_en_o` and `proto_err_o` are zero, and they stay zero until the first strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Line strobe: capture on rise, drive on fall |
| polarity_i | input | 1 | Reference half swap for the coming line |
| start_i | input | 1 | Start pulse of the next line's capture, used only for the timing check |
| line_data_i | input | NUM_CH*CODE_W | Captured line, one code per channel |
| code_o | output | NUM_CH*CODE_W | Latched codes for the analog stage |
| upper_sel_o | output | NUM_CH | Per channel: 1 selects the upper reference set |
| drive_en_o | output | NUM_CH | Per channel: 1 drives, 0 means high impedance |
| proto_err_o | output | 1 | One-cycle strobe timing violation flag |

## Verification
Suppose the latch catches the wrong line, or catches it at the wrong edge. The fault shows on `code_o` in the cycle right after the strobe falls, when the bench compares it with the data that was present at the rise. A polarity register that is sampled at the wrong moment shows up when the polarity input is flipped while the strobe is high. The steering outputs then give the flipped pattern on the very next drive cycle. Counter faults in the timing guard show up as a missing error pulse, or an extra one, one cycle after the offending sample. The bench probes both sides of each 2-clock limit.

// File: rtl/lsl_pkg.sv
package lsl_pkg;
  localparam int unsigned DEF_NUM_CH    = 8;
  localparam int unsigned DEF_CODE_W    = 6;
  localparam int unsigned DEF_MIN_STB   = 2;
  localparam int unsigned DEF_MIN_GAP   = 2;

  // Reference half for a channel: even index takes the upper set when pol=0
  function automatic logic upper_for(input int unsigned idx, input logic pol);
    return ((idx % 2) == 0) ? ~pol : pol;
  endfunction
endpackage

// File: rtl/lsl_strobe_edges.sv
module lsl_strobe_edges (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic rise_o,
  output logic fall_o
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;
  assign fall_o = ~strobe_i & strobe_q;
endmodule

// File: rtl/lsl_line_latch.sv
module lsl_line_latch #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rise_i,
  input  logic                     fall_i,
  input  logic [NUM_CH*CODE_W-1:0] line_i,
  output logic [NUM_CH*CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] hold_q [NUM_CH];
  logic [CODE_W-1:0] out_q  [NUM_CH];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q[k] <= '0;
        out_q[k]  <= '0;
      end else begin
        if (rise_i) hold_q[k] <= line_i[k*CODE_W +: CODE_W];
        if (fall_i) out_q[k]  <= hold_q[k];
      end
    end
    assign code_o[k*CODE_W +: CODE_W] = out_q[k];
  end
endmodule

// File: rtl/lsl_polarity_steer.sv
module lsl_polarity_steer
  import lsl_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              pol_i,
  output logic [NUM_CH-1:0] upper_sel_o,
  output logic [NUM_CH-1:0] drive_en_o
);
  logic pol_q;

  always_ff @(posedge clk) begin
    if (rst)         pol_q <= 1'b0;
    else if (rise_i) pol_q <= pol_i;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        upper_sel_o[k] <= 1'b0;
        drive_en_o[k]  <= 1'b0;
      end else if (strobe_i) begin
        drive_en_o[k]  <= 1'b0;
      end else if (fall_i) begin
        drive_en_o[k]  <= 1'b1;
        upper_sel_o[k] <= upper_for(k, pol_q);
      end
    end
  end
endmodule

// File: rtl/lsl_timing_guard.sv
module lsl_timing_guard #(
  parameter int unsigned MIN_STB_CYC   = 2,
  parameter int unsigned MIN_START_GAP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic start_i,
  output logic err_o
);
  localparam int unsigned WW = $clog2(MIN_STB_CYC + 2);
  localparam int unsigned GW = $clog2(MIN_START_GAP + 2);
  localparam logic [WW-1:0] W_LIM = WW'(MIN_STB_CYC);
  localparam logic [GW-1:0] G_LIM = GW'(MIN_START_GAP);

  logic [WW-1:0] hi_cnt;
  logic [GW-1:0] gap_cnt;
  logic          armed;
  logic          short_fault, early_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
    end else if (rise_i) begin
      hi_cnt <= WW'(1);
    end else if (strobe_i && hi_cnt < W_LIM) begin
      hi_cnt <= hi_cnt + WW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
      armed   <= 1'b0;
    end else if (rise_i) begin
      gap_cnt <= GW'(1);
      armed   <= (G_LIM > GW'(1));
    end else if (armed) begin
      gap_cnt <= gap_cnt + GW'(1);
      if (gap_cnt + GW'(1) >= G_LIM) armed <= 1'b0;
    end
  end

  assign short_fault = fall_i && (hi_cnt < W_LIM);
  assign early_fault = start_i &&
                       ((rise_i && G_LIM != '0) || (armed && gap_cnt < G_LIM));

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= short_fault | early_fault;
  end
endmodule

// File: rtl/line_strobe_latch.sv
module line_strobe_latch #(
  parameter int unsigned NUM_CH        = lsl_pkg::DEF_NUM_CH,
  parameter int unsigned CODE_W        = lsl_pkg::DEF_CODE_W,
  parameter int unsigned MIN_STB_CYC   = lsl_pkg::DEF_MIN_STB,
  parameter int unsigned MIN_START_GAP = lsl_pkg::DEF_MIN_GAP
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     strobe_i,
  input  logic                     polarity_i,
  input  logic                     start_i,
  input  logic [NUM_CH*CODE_W-1:0] line_data_i,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        upper_sel_o,
  output logic [NUM_CH-1:0]        drive_en_o,
  output logic                     proto_err_o
);
  logic rise, fall;

  lsl_strobe_edges u_edges (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .rise_o(rise), .fall_o(fall)
  );

  lsl_line_latch #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall),
    .line_i(line_data_i), .code_o(code_o)
  );

  lsl_polarity_steer #(.NUM_CH(NUM_CH)) u_steer (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .rise_i(rise), .fall_i(fall),
    .pol_i(polarity_i), .upper_sel_o(upper_sel_o), .drive_en_o(drive_en_o)
  );

  lsl_timing_guard #(.MIN_STB_CYC(MIN_STB_CYC), .MIN_START_GAP(MIN_START_GAP)) u_guard (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .rise_i(rise), .fall_i(fall),
    .start_i(start_i), .err_o(proto_err_o)
  );
endmodule

// File: rtl/lsl_checker.sv
module lsl_checker #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     strobe_i,
  input logic                     start_i,
  input logic [NUM_CH*CODE_W-1:0] code_o,
  input logic [NUM_CH-1:0]        upper_sel_o,
  input logic [NUM_CH-1:0]        drive_en_o,
  input logic                     proto_err_o
);
  AST_HIZ_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    strobe_i |=> (drive_en_o == '0)); // R3

  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    (!strobe_i && $past(strobe_i)) |=> (drive_en_o == '1)); // R3

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !(!strobe_i && $past(strobe_i)) |=> $stable(code_o)); // R2

  if (NUM_CH >= 2) begin : g_pair
    AST_NEIGHBOURS_OPPOSITE: assert property (@(posedge clk) disable iff (rst)
      (drive_en_o[0]) |-> (upper_sel_o[0] != upper_sel_o[1])); // R4
  end

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |-> ($past(start_i) || ($past(strobe_i, 2) && !$past(strobe_i)))); // R5 R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (drive_en_o == '0 && code_o == '0 && !proto_err_o)); // R7
endmodule

bind line_strobe_latch lsl_checker #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_lsl_chk (
  .clk(clk), .rst(rst), .strobe_i(strobe_i), .start_i(start_i),
  .code_o(code_o), .upper_sel_o(upper_sel_o), .drive_en_o(drive_en_o),
  .proto_err_o(proto_err_o)
);

// File: tb/test_line_strobe_latch.sv
module test_line_strobe_latch;
  localparam int NCH = 8;
  localparam int CW  = 6;
  localparam int DW  = NCH * CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0, pol = 1'b0, start = 1'b0;
  logic [DW-1:0]  data = '0;
  logic [DW-1:0]  code;
  logic [NCH-1:0] upper, en;
  logic           err;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  line_strobe_latch i_line_strobe_latch (
    .clk(clk), .rst(rst), .strobe_i(strobe), .polarity_i(pol), .start_i(start),
    .line_data_i(data), .code_o(code), .upper_sel_o(upper), .drive_en_o(en),
    .proto_err_o(err)
  );

  // {polarity, strobe width, line data}
  localparam logic [DW+3:0] VEC [0:4] = '{
    {1'b0, 3'd2, 48'hFFF_000_FFF_000},
    {1'b1, 3'd3, 48'h041_083_0C4_105},
    {1'b0, 3'd4, 48'hA5A_5A5_3C3_C3C},
    {1'b1, 3'd2, 48'h000_000_000_000},
    {1'b1, 3'd5, 48'hFFF_FFF_FFF_FFF}
  };

  function automatic logic [NCH-1:0] exp_upper(input logic p);
    logic [NCH-1:0] r;
    for (int k = 0; k < NCH; k++) r[k] = (k % 2 == 0) ? ~p : p;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One line: strobe high for w samples, data/pol optionally disturbed while high
  task automatic run_line(input logic [DW-1:0] d, input logic p, input int w,
                          input bit disturb);
    @(negedge clk); data = d; pol = p; strobe = 1'b1;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      check(en == '0, "R3 hiz while strobe high", 64'(en), 64'd0);
      if (disturb) begin data = ~d; pol = ~p; end
    end
    strobe = 1'b0;
    @(negedge clk);
    check(code == d, "R1/R2 latched code", 64'(code), 64'(d));
    check(upper == exp_upper(p), "R4 polarity steering", 64'(upper), 64'(exp_upper(p)));
    check(en == '1, "R3 driven after fall", 64'(en), 64'hFF);
    check(err == (w < 2), "R5 width flag", 64'(err), 64'(w < 2));
    @(negedge clk);
    check(code == d, "R2 code held", 64'(code), 64'(d));
    check(err == 1'b0, "R5 flag one cycle", 64'(err), 64'd0);
  endtask

  task automatic start_gap(input int k);
    bit seen = 0;
    @(negedge clk); strobe = 1'b1; start = (k == 0);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (err) seen = 1;
      start = (i == k);
    end
    strobe = 1'b0; start = 1'b0;
    @(negedge clk); if (err) seen = 1;
    check(seen == (k < 2), $sformatf("R6 start offset %0d", k), 64'(seen), 64'(k < 2));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(code == '0 && en == '0 && upper == '0 && !err, "R7 state in reset",
          64'(code), 64'd0);
    rst = 1'b0;
    data = '1; pol = 1'b1; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    check(code == '0, "R7 code zero before first strobe", 64'(code), 64'd0);
    check(en == '0, "R7 hiz before first strobe", 64'(en), 64'd0);
    check(!err, "R7 no flag before first strobe", 64'(err), 64'd0);

    for (int v = 0; v < 5; v++)
      run_line(VEC[v][DW-1:0], VEC[v][DW+3], int'(VEC[v][DW+2:DW]), 1'b0);

    // R1 and R4: data and polarity change while the strobe is high
    run_line(48'h123_456_789_ABC, 1'b0, 3, 1'b1);
    run_line(48'h0F0_F0F_00F_F00, 1'b1, 2, 1'b1);

    // R5: single-sample strobe
    run_line(48'h111_222_333_444, 1'b0, 1, 1'b0);

    // R6: start pulse offsets around the limit
    for (int k = 0; k < 4; k++) start_gap(k);

    // R7: reset mid-operation clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(code == '0 && en == '0 && upper == '0, "R7 cleared by reset",
          64'(code), 64'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule